// File: doc/BRIEF.md
# Frame-locked serial word transmitter

This block sends one result word per frame as a serial bit stream. A master clock drives everything. Two free-running dividers made from that clock produce a bit strobe and a frame strobe. The frame strobe period is exactly one bit-strobe period multiplied by the word width, so each frame holds one slot for every bit of the word. With the default parameters the master clock is 61.44 kHz. The bit strobe then runs at 240 Hz and the frame strobe at 8 Hz, giving 30 slots per frame.

A client presents a word together with a one-cycle load request. The word is held until the next frame boundary. It then moves into the shift register and goes out most significant bit first, one bit per slot. A one-hot slot select vector runs alongside the serial bit and marks the slot being sent. A frame-start marker flags slot 0, and a busy flag covers all slots of a frame that carries a word. Nothing is ever loaded in the middle of a frame. No derived clock exists: the strobes are clock enables on the master clock.

Top module: `frame_serializer`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, serial_o, busy_o, frame_start_o and slot_sel_o are all 0, whatever was being sent before reset.
- R2: Each slot lasts exactly BIT_DIV master-clock cycles, and a frame lasts exactly WORD_W slots (WORD_W*BIT_DIV cycles). The first frame boundary falls at master-clock edge WORD_W*BIT_DIV after reset release.
- R3: A word presented with load_req_i high is sent in the frame that begins at the next frame boundary. A request sampled on the same edge as a frame boundary is deferred to the frame after that one.
- R4: Slot k of a frame carries bit WORD_W-1-k of the word, so slot 0 carries the MSB and slot WORD_W-1 carries bit 0.
- R5: While busy_o is high, slot_sel_o has exactly bit k set during slot k. While busy_o is low, slot_sel_o is all zero.
- R6: frame_start_o is high during slot 0 of a busy frame and low at all other times.
- R7: busy_o is high for every slot of a frame that carries a word and low in frames with no pending word; serial_o is 0 whenever busy_o is low.
- R8: Requests made during a busy frame do not change the bits or the slot select of that frame. A word requested during one frame follows it with no idle gap.
- R9: If several requests arrive before one frame boundary, the word of the last one is sent.
- R10: After the last slot the position wraps to slot 0, and this wrap falls on the same edge as the frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | WORD_W | Word to send |
| load_req_i | input | 1 | One-cycle request to capture word_i |
| serial_o | output | 1 | Serial data bit, MSB first |
| slot_sel_o | output | WORD_W | One-hot marker of the slot being sent |
| frame_start_o | output | 1 | High during slot 0 of a busy frame |
| busy_o | output | 1 | High while a word is being sent |

## Verification
Two events can fall in the same cycle.

- **Frame boundary and load request.** Both the shift-register load and the position wrap happen on the final bit strobe of a frame. A client request may also land on that same edge. The bench counts master-clock edges from reset release and raises load_req_i so that it is sampled on exactly the edge of the first frame boundary. It then judges that busy_o stays low for the whole of that frame and rises only at the following boundary, carrying the deferred word.
- **Frame boundary and bit strobe.** Back-to-back frames of the vector table make the boundary and the bit strobe coincide repeatedly. Each time, the bench checks that slot 0 of the new word appears with no gap and no extra shift.

// File: rtl/frame_ser_pkg.sv
package frame_ser_pkg;
  localparam int unsigned DEF_WORD_W  = 30;
  localparam int unsigned DEF_BIT_DIV = 256;

  function automatic int unsigned cnt_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/fs_strobe.sv
module fs_strobe #(
  parameter int unsigned DIV = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = frame_ser_pkg::cnt_w(DIV);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/fs_slot_ctr.sv
module fs_slot_ctr #(
  parameter int unsigned SLOTS = 30
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             realign_i,
  input  logic             active_i,
  output logic [SLOTS-1:0] sel_o
);
  localparam int unsigned PW = frame_ser_pkg::cnt_w(SLOTS);

  logic [PW-1:0] pos_q;

  // frame boundary realigns the position regardless of the step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       pos_q <= '0;
    else if (realign_i)                pos_q <= '0;
    else if (step_i) begin
      if (pos_q == PW'(SLOTS - 1))     pos_q <= '0;
      else                             pos_q <= pos_q + 1'b1;
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_dec
    assign sel_o[g] = active_i && (pos_q == PW'(g));
  end
endmodule

// File: rtl/fs_shifter.sv
module fs_shifter #(
  parameter int unsigned W = 30
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         shift_i,
  output logic         msb_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= data_i;
    else if (shift_i) sr_q <= {sr_q[W-2:0], 1'b0};
  end

  assign msb_o = sr_q[W-1];
endmodule

// File: rtl/frame_serializer.sv
module frame_serializer
  import frame_ser_pkg::*;
#(
  parameter int unsigned WORD_W  = DEF_WORD_W,
  parameter int unsigned BIT_DIV = DEF_BIT_DIV
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              load_req_i,
  output logic              serial_o,
  output logic [WORD_W-1:0] slot_sel_o,
  output logic              frame_start_o,
  output logic              busy_o
);
  localparam int unsigned FRAME_DIV = BIT_DIV * WORD_W;

  logic              bit_tick, frame_tick;
  logic [WORD_W-1:0] hold_q;
  logic              pend_q, busy_q, msb;

  fs_strobe #(.DIV(BIT_DIV)) u_bit_stb (
    .clk_i (clk_i), .rst_ni(rst_ni), .tick_o(bit_tick)
  );

  fs_strobe #(.DIV(FRAME_DIV)) u_frm_stb (
    .clk_i (clk_i), .rst_ni(rst_ni), .tick_o(frame_tick)
  );

  // request at a boundary stays pending for the next frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      pend_q <= 1'b0;
    end else if (load_req_i) begin
      hold_q <= word_i;
      pend_q <= 1'b1;
    end else if (frame_tick) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         busy_q <= 1'b0;
    else if (frame_tick) busy_q <= pend_q;
  end

  fs_shifter #(.W(WORD_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (frame_tick & pend_q),
    .data_i (hold_q),
    .shift_i(bit_tick & ~frame_tick & busy_q),
    .msb_o  (msb)
  );

  fs_slot_ctr #(.SLOTS(WORD_W)) u_slot (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (bit_tick),
    .realign_i(frame_tick),
    .active_i (busy_q),
    .sel_o    (slot_sel_o)
  );

  assign serial_o      = busy_q & msb;
  assign frame_start_o = slot_sel_o[0];
  assign busy_o        = busy_q;
endmodule

// File: rtl/frame_serializer_chk.sv
module frame_serializer_chk #(
  parameter int unsigned WORD_W = 30
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bit_tick,
  input logic              frame_tick,
  input logic              serial_o,
  input logic [WORD_W-1:0] slot_sel_o,
  input logic              frame_start_o,
  input logic              busy_o
);
  // R5
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(slot_sel_o));

  // R5
  sel_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> $countones(slot_sel_o) == 1);

  // R7
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !serial_o);

  // R6
  start_slot0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> busy_o && slot_sel_o[0]);

  // R3
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> frame_start_o);

  // R10
  strobe_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_tick |-> bit_tick);

  // R8
  slot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !bit_tick) |=> $stable(slot_sel_o) && $stable(serial_o));

  // R10
  slot_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && bit_tick && !frame_tick) |=> slot_sel_o == ($past(slot_sel_o) << 1));

  // R10
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_tick |=> !busy_o || slot_sel_o[0]);
endmodule

bind frame_serializer frame_serializer_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bit_tick     (bit_tick),
  .frame_tick   (frame_tick),
  .serial_o     (serial_o),
  .slot_sel_o   (slot_sel_o),
  .frame_start_o(frame_start_o),
  .busy_o       (busy_o)
);

// File: tb/frame_serializer_test.sv
module frame_serializer_test;
  localparam int unsigned W   = 30;
  localparam int unsigned DIV = 4;
  localparam int unsigned FRM = W * DIV;
  localparam int          NV  = 5;
  localparam logic [W-1:0] VEC [NV] = '{
    30'h2AAA_AAAA, 30'h3FFF_FFFF, 30'h0000_0001, 30'h2000_0000, 30'h1234_5678
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] word = '0;
  logic         req = 1'b0;
  logic         ser, fs, busy;
  logic [W-1:0] sel;
  int           n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  frame_serializer #(.WORD_W(W), .BIT_DIV(DIV)) uut (
    .clk_i(clk), .rst_ni(rst_n), .word_i(word), .load_req_i(req),
    .serial_o(ser), .slot_sel_o(sel), .frame_start_o(fs), .busy_o(busy)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(busy == 1'b0, {tag, " busy"}, 32'(busy), 0);
    chk(ser == 1'b0, {tag, " serial"}, 32'(ser), 0);
    chk(fs == 1'b0, {tag, " frame_start"}, 32'(fs), 0);
    chk(sel == '0, {tag, " slot_sel"}, 32'(sel), 0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #1;
    chk_idle("R1 in reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1 after release");

    // vector table, back-to-back frames
    word = VEC[0]; req = 1'b1;
    @(negedge clk); req = 1'b0;
    while (!fs) @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      for (int k = 0; k < int'(W); k++) begin
        chk(ser == VEC[i][W-1-k], "R4 slot bit", 32'(ser), 32'(VEC[i][W-1-k]));
        chk(sel == (W'(1) << k), "R5 slot select", 32'(sel), 32'(W'(1) << k));
        chk(fs == (k == 0), "R6 frame start", 32'(fs), 32'(k == 0));
        chk(busy == 1'b1, "R7 busy", 32'(busy), 1);
        for (int j = 0; j < int'(DIV); j++) begin
          if (j == int'(DIV) / 2)
            chk(ser == VEC[i][W-1-k], "R2 R8 mid-slot bit", 32'(ser),
                32'(VEC[i][W-1-k]));
          // decoy at slot 3, real word at slot 5 (R9)
          req = (j == 0) && (k == 3 || k == 5) && (i + 1 < NV);
          if (i + 1 < NV) word = (k == 3) ? ~VEC[i+1] : VEC[i+1];
          @(negedge clk);
        end
      end
    end
    req = 1'b0;
    chk_idle("R7 R10 idle after last frame");
    repeat (FRM / 2) @(negedge clk);
    chk_idle("R7 idle mid frame");

    // reset mid-frame
    word = 30'h3C0F_0F0F; req = 1'b1;
    @(negedge clk); req = 1'b0;
    while (!fs) @(negedge clk);
    repeat (2 * DIV + 1) @(negedge clk);
    chk(busy == 1'b1, "R7 busy before reset", 32'(busy), 1);
    rst_n = 1'b0;
    #1;
    chk_idle("R1 reset mid-frame");
    @(negedge clk);
    rst_n = 1'b1;

    // request sampled on the first frame boundary edge
    repeat (FRM - 1) @(negedge clk);
    word = 30'h2F00_00F1; req = 1'b1;
    @(negedge clk); req = 1'b0;
    chk(busy == 1'b0, "R3 deferred at boundary", 32'(busy), 0);
    repeat (FRM - 1) @(negedge clk);
    chk(busy == 1'b0, "R3 R2 still idle before boundary", 32'(busy), 0);
    @(negedge clk);
    chk(fs == 1'b1, "R3 R2 deferred frame start", 32'(fs), 1);
    chk(ser == 1'b1, "R3 R4 deferred msb", 32'(ser), 1);
    repeat (DIV) @(negedge clk);
    chk(ser == 1'b0, "R4 deferred bit 28", 32'(ser), 0);
    chk(sel == W'(2), "R5 deferred slot 1", 32'(sel), 2);
    finish_run();
  end
endmodule